// File: doc/BRIEF.md
# Multi-ring DMA control and status register file

This block is the software-visible register front end of a DMA engine that serves up to eight transmit rings and eight receive rings. It sits on a simple 32-bit bus of valid, write, byte address, byte enables and write data. Each access selects one word in a 4 KB window. Each word has an access type, and the type decides what a read returns and what a write does. Words that no table entry claims read as zero and ignore writes.

Two halt-status words do more than clear bits when written. A write to the transmit one asks the descriptor engine to walk each ring whose bit is set. A write to the receive one asks for a walk only on rings whose halt bit was already clear. The block sends these requests as one-cycle, one-bit-per-ring pulses. Each ring also has a base-address word. Writing it aligns the address to eight bytes and loads the same value into that ring's live descriptor pointer, which the fetch engine then advances from the aligned base.

Top module: `ringreg_top`

## Requirements
- R1: An access is taken only when its byte address has bits above bit 11 all zero and bits 1:0 both zero. The word index is address bits 11:2.
- R2: A taken read returns its value on `bus_rdata` at the first rising edge after the read. A write-only word reads as 0. A word that no table entry claims reads as 0. Every other word returns its stored value.
- R3: Generic writes follow the access type. Read-write and write-only words store the written value. Write-1-to-clear words clear each bit written as 1. Read-only and unclaimed words do not change.
- R4: Writing the transmit halt word (index 0x040) asserts `tx_walk[i]` for every ring i whose data bit 31−i is 1. The stored word then has every bit that was written as 1 cleared.
- R5: Writing the receive halt word (index 0x050) asserts `rx_walk[i]` only if data bit 23−i is 1 and the stored bit 23−i was 0 before the write. The stored word then has every bit that was written as 1 cleared.
- R6: Writing transmit base n (index 0x060+n) stores the data with bits 2:0 forced to 0. The same value is loaded into transmit pointer n (index 0x070+n).
- R7: Writing receive base n (index 0x080+n) stores the data with bits 2:0 forced to 0. The same value is loaded into receive pointer n (index 0x090+n). Pointers are read-write words in their own right.
- R8: After reset the table takes effect, and every word outside it is 0:

  | Index | Type | Value |
  |---|---|---|
  | 0x000 | read-write | 0x00001000 |
  | 0x001 | write-only | 0 |
  | 0x002 | write-1-to-clear | 0xFFFF0000 |
  | 0x003 | read-only | 0x5A010003 |
  | 0x040 | transmit halt word | 0xFF000000 |
  | 0x050 | receive halt word | 0x00FF0000 |
  | bases and pointers | read-write | 0 |

- R9: Walk outputs are high only in the single cycle after the taken write that caused them, and they are low otherwise.
- R10: An access outside the window, with an unaligned address, or with byte enables other than 4'hF changes no state and raises no walk. A read of that kind returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte enables, all four must be set |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, held between reads |
| tx_walk | output | NUM_RINGS | Transmit ring walk request pulses |
| rx_walk | output | NUM_RINGS | Receive ring walk request pulses |

## Verification
Read data and walk pulses each pass through exactly one register, so both are due at the first rising edge after the access. The bench drives every access on a falling edge and samples `bus_rdata` and both walk vectors on the next falling edge. It then samples the walk vectors again one falling edge later, with no access in between, to confirm they have dropped. A bench-side word model updated with the access-type rules supplies every expected value, including the receive-side condition that depends on the halt bit's value before the write.

// File: rtl/ringreg_pkg.sv
package ringreg_pkg;

   localparam int WORD_W     = 32;
   localparam int IDX_W      = 10;
   localparam int WIN_BITS   = IDX_W + 2;
   localparam int RING_SLOTS = 8;
   localparam int ALIGN_BITS = 3;

   typedef logic [WORD_W-1:0] word_t;
   typedef logic [IDX_W-1:0]  idx_t;

   typedef enum logic [2:0] {
      ACC_UNK = 3'd0,
      ACC_RW  = 3'd1,
      ACC_WO  = 3'd2,
      ACC_W1C = 3'd3,
      ACC_RO  = 3'd4
   } acc_e;

   typedef struct packed {
      idx_t  idx;
      acc_e  acc;
      word_t rst;
   } gen_entry_t;

   // Plain words handled by the generic write path
   localparam int GEN_N = 4;
   localparam gen_entry_t GEN_TAB [GEN_N] = '{
      '{10'h000, ACC_RW,  32'h0000_1000},
      '{10'h001, ACC_WO,  32'h0000_0000},
      '{10'h002, ACC_W1C, 32'hFFFF_0000},
      '{10'h003, ACC_RO,  32'h5A01_0003}
   };

   // Ring control words
   localparam idx_t  IDX_TXSTAT = 10'h040;
   localparam idx_t  IDX_RXSTAT = 10'h050;
   localparam idx_t  IDX_TXBASE = 10'h060;
   localparam idx_t  IDX_TXPTR  = 10'h070;
   localparam idx_t  IDX_RXBASE = 10'h080;
   localparam idx_t  IDX_RXPTR  = 10'h090;
   localparam word_t TXSTAT_RST = 32'hFF00_0000;
   localparam word_t RXSTAT_RST = 32'h00FF_0000;
   localparam int    TX_TOP_BIT = 31;
   localparam int    RX_TOP_BIT = 23;

endpackage

// File: rtl/ringreg_decode.sv
module ringreg_decode
   import ringreg_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [3:0]        bus_be,
   output logic              acc_ok,
   output logic              wr_ok,
   output logic              rd_ok,
   output idx_t              idx
);

   logic hi_zero;

   if (ADDR_W < WIN_BITS) begin : g_bad_width
      $error("ringreg_decode: ADDR_W must cover the register window");
   end

   if (ADDR_W > WIN_BITS) begin : g_hi
      assign hi_zero = (bus_addr[ADDR_W-1:WIN_BITS] == '0);
   end else begin : g_flat
      assign hi_zero = 1'b1;
   end

   assign idx    = bus_addr[WIN_BITS-1:2];
   assign acc_ok = bus_valid && hi_zero && (bus_addr[1:0] == 2'b00) && (bus_be == 4'hF);
   assign wr_ok  = acc_ok && bus_write;
   assign rd_ok  = acc_ok && !bus_write;

endmodule

// File: rtl/ringreg_halt.sv
module ringreg_halt
   import ringreg_pkg::*;
#(
   parameter int    NUM_RINGS = 8,
   parameter int    TOP_BIT   = 31,
   parameter word_t RST_VAL   = '0,
   parameter bit    EDGE_ONLY = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  word_t                wdata,
   output word_t                stat_q,
   output logic [NUM_RINGS-1:0] walk_q
);

   logic [NUM_RINGS-1:0] req;

   if (NUM_RINGS < 1 || NUM_RINGS > RING_SLOTS) begin : g_bad_rings
      $error("ringreg_halt: NUM_RINGS out of range");
   end
   if (TOP_BIT > WORD_W - 1 || TOP_BIT - NUM_RINGS + 1 < 0) begin : g_bad_top
      $error("ringreg_halt: TOP_BIT does not fit the ring field");
   end

   for (genvar i = 0; i < NUM_RINGS; i++) begin : g_ring
      if (EDGE_ONLY) begin : g_edge
         assign req[i] = wr_en && wdata[TOP_BIT-i] && !stat_q[TOP_BIT-i];
         AST_RX_WALK_FROM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            walk_q[i] |-> !$past(stat_q[TOP_BIT-i])); // R5
      end else begin : g_level
         assign req[i] = wr_en && wdata[TOP_BIT-i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= RST_VAL;
         walk_q <= '0;
      end else begin
         walk_q <= req;
         if (wr_en) begin
            stat_q <= stat_q & ~wdata;
         end
      end
   end

   AST_STAT_WRITTEN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((stat_q & $past(wdata)) == '0)); // R4
   AST_WALK_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_q != '0) |-> $past(wr_en)); // R9

endmodule

// File: rtl/ringreg_base_bank.sv
module ringreg_base_bank
   import ringreg_pkg::*;
#(
   parameter int NUM_RINGS = 8,
   parameter int ALIGN     = ALIGN_BITS
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_RINGS-1:0]        base_we,
   input  logic [NUM_RINGS-1:0]        ptr_we,
   input  word_t                       wdata,
   output word_t [NUM_RINGS-1:0]       base_q,
   output word_t [NUM_RINGS-1:0]       ptr_q
);

   localparam word_t ALIGN_MASK = ~word_t'((1 << ALIGN) - 1);

   if (ALIGN < 0 || ALIGN >= WORD_W) begin : g_bad_align
      $error("ringreg_base_bank: ALIGN out of range");
   end

   word_t aligned;
   assign aligned = wdata & ALIGN_MASK;

   for (genvar n = 0; n < NUM_RINGS; n++) begin : g_ring
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q[n] <= '0;
            ptr_q[n]  <= '0;
         end else if (base_we[n]) begin
            base_q[n] <= aligned;
            ptr_q[n]  <= aligned;
         end else if (ptr_we[n]) begin
            ptr_q[n]  <= wdata;
         end
      end

      AST_PTR_FOLLOWS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
         base_we[n] |=> (ptr_q[n] == base_q[n])); // R6
   end

endmodule

// File: rtl/ringreg_top.sv
module ringreg_top
   import ringreg_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int NUM_RINGS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_valid,
   input  logic                 bus_write,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [3:0]           bus_be,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   output logic [NUM_RINGS-1:0] tx_walk,
   output logic [NUM_RINGS-1:0] rx_walk
);

   if (NUM_RINGS < 1 || NUM_RINGS > RING_SLOTS) begin : g_bad_rings
      $error("ringreg_top: NUM_RINGS out of range");
   end

   logic acc_ok, wr_ok, rd_ok;
   idx_t idx;

   ringreg_decode #(.ADDR_W(ADDR_W)) u_decode (
      .bus_valid (bus_valid),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .bus_be    (bus_be),
      .acc_ok    (acc_ok),
      .wr_ok     (wr_ok),
      .rd_ok     (rd_ok),
      .idx       (idx)
   );

   // Generic words from the constant table
   word_t gen_q [GEN_N];

   for (genvar g = 0; g < GEN_N; g++) begin : g_gen
      localparam idx_t  G_IDX = GEN_TAB[g].idx;
      localparam word_t G_RST = GEN_TAB[g].rst;
      word_t q_r;
      if (GEN_TAB[g].acc == ACC_RW || GEN_TAB[g].acc == ACC_WO) begin : g_store
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    q_r <= G_RST;
            else if (wr_ok && idx == G_IDX) q_r <= bus_wdata;
         end
      end else if (GEN_TAB[g].acc == ACC_W1C) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    q_r <= G_RST;
            else if (wr_ok && idx == G_IDX) q_r <= q_r & ~bus_wdata;
         end
      end else begin : g_fixed
         assign q_r = G_RST;
      end
      assign gen_q[g] = q_r;
   end

   // Halt status words
   word_t tx_stat, rx_stat;

   ringreg_halt #(
      .NUM_RINGS (NUM_RINGS),
      .TOP_BIT   (TX_TOP_BIT),
      .RST_VAL   (TXSTAT_RST),
      .EDGE_ONLY (1'b0)
   ) u_tx_halt (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_ok && idx == IDX_TXSTAT),
      .wdata  (bus_wdata),
      .stat_q (tx_stat),
      .walk_q (tx_walk)
   );

   ringreg_halt #(
      .NUM_RINGS (NUM_RINGS),
      .TOP_BIT   (RX_TOP_BIT),
      .RST_VAL   (RXSTAT_RST),
      .EDGE_ONLY (1'b1)
   ) u_rx_halt (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_ok && idx == IDX_RXSTAT),
      .wdata  (bus_wdata),
      .stat_q (rx_stat),
      .walk_q (rx_walk)
   );

   // Ring base and descriptor pointer banks
   logic [NUM_RINGS-1:0] tx_base_we, tx_ptr_we, rx_base_we, rx_ptr_we;
   word_t [NUM_RINGS-1:0] tx_base, tx_ptr, rx_base, rx_ptr;

   for (genvar n = 0; n < NUM_RINGS; n++) begin : g_ring_we
      assign tx_base_we[n] = wr_ok && (idx == idx_t'(IDX_TXBASE + n));
      assign tx_ptr_we[n]  = wr_ok && (idx == idx_t'(IDX_TXPTR  + n));
      assign rx_base_we[n] = wr_ok && (idx == idx_t'(IDX_RXBASE + n));
      assign rx_ptr_we[n]  = wr_ok && (idx == idx_t'(IDX_RXPTR  + n));
   end

   ringreg_base_bank #(.NUM_RINGS(NUM_RINGS)) u_tx_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .base_we (tx_base_we),
      .ptr_we  (tx_ptr_we),
      .wdata   (bus_wdata),
      .base_q  (tx_base),
      .ptr_q   (tx_ptr)
   );

   ringreg_base_bank #(.NUM_RINGS(NUM_RINGS)) u_rx_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .base_we (rx_base_we),
      .ptr_we  (rx_ptr_we),
      .wdata   (bus_wdata),
      .base_q  (rx_base),
      .ptr_q   (rx_ptr)
   );

   // Read selection
   word_t rd_val;

   always_comb begin
      rd_val = '0;
      for (int g = 0; g < GEN_N; g++) begin
         if (idx == GEN_TAB[g].idx && GEN_TAB[g].acc != ACC_WO) rd_val = gen_q[g];
      end
      if (idx == IDX_TXSTAT) rd_val = tx_stat;
      if (idx == IDX_RXSTAT) rd_val = rx_stat;
      for (int n = 0; n < NUM_RINGS; n++) begin
         if (idx == idx_t'(IDX_TXBASE + n)) rd_val = tx_base[n];
         if (idx == idx_t'(IDX_TXPTR  + n)) rd_val = tx_ptr[n];
         if (idx == idx_t'(IDX_RXBASE + n)) rd_val = rx_base[n];
         if (idx == idx_t'(IDX_RXPTR  + n)) rd_val = rx_ptr[n];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       bus_rdata <= '0;
      else if (rd_ok)                   bus_rdata <= rd_val;
      else if (bus_valid && !bus_write) bus_rdata <= '0;
   end

   AST_IGNORED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && !acc_ok) |=> (bus_rdata == '0)); // R10
   AST_IGNORED_WRITE_NO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && !acc_ok) |=> (tx_walk == '0 && rx_walk == '0)); // R10
   AST_RX_BASE_LOADS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_base_we != '0) |=> ((rx_ptr & ~rx_base) == '0 || rx_ptr == rx_base)); // R7

endmodule

// File: tb/ringreg_top_tb_top.sv
`timescale 1ns/1ps
module ringreg_top_tb_top;

   localparam int WORDS = 1024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  tx_walk, rx_walk;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] model [WORDS];

   always #2.5 clk = ~clk;

   ringreg_top #(.ADDR_W(16), .NUM_RINGS(8)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_valid (bus_valid),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .bus_be    (bus_be),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .tx_walk   (tx_walk),
      .rx_walk   (rx_walk)
   );

   // 0 unclaimed, 1 rw, 2 wo, 3 w1c, 4 ro, 5 tx base, 6 rx base
   function automatic int kind(input int ix);
      if (ix == 0) return 1;
      if (ix == 1) return 2;
      if (ix == 2 || ix == 'h40 || ix == 'h50) return 3;
      if (ix == 3) return 4;
      if (ix >= 'h60 && ix < 'h68) return 5;
      if (ix >= 'h80 && ix < 'h88) return 6;
      if ((ix >= 'h70 && ix < 'h78) || (ix >= 'h90 && ix < 'h98)) return 1;
      return 0;
   endfunction

   function automatic bit taken(input logic [15:0] a, input logic [3:0] be);
      return (a[15:12] == 4'h0) && (a[1:0] == 2'b00) && (be == 4'hF);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < WORDS; i++) model[i] = '0;
      model[0]    = 32'h0000_1000;
      model[2]    = 32'hFFFF_0000;
      model[3]    = 32'h5A01_0003;
      model['h40] = 32'hFF00_0000;
      model['h50] = 32'h00FF_0000;
   endtask

   // Called right after a falling edge
   task automatic do_write(input logic [15:0] a, input logic [31:0] d,
                           input logic [3:0] be, input string tag);
      logic [7:0] etx, erx;
      int ix;
      etx = '0;
      erx = '0;
      ix  = int'(a[11:2]);
      if (taken(a, be)) begin
         if (ix == 'h40) for (int i = 0; i < 8; i++) etx[i] = d[31-i];
         if (ix == 'h50) for (int i = 0; i < 8; i++) erx[i] = d[23-i] & ~model[ix][23-i];
         case (kind(ix))
            1, 2: model[ix] = d;
            3:    model[ix] = model[ix] & ~d;
            5, 6: begin
               model[ix]        = d & ~32'h7;
               model[ix + 'h10] = d & ~32'h7;
            end
            default: ;
         endcase
      end
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
      chk({tag, " tx_walk"}, {24'b0, tx_walk}, {24'b0, etx});
      chk({tag, " rx_walk"}, {24'b0, rx_walk}, {24'b0, erx});
      @(negedge clk);
      chk("R9 tx_walk drop", {24'b0, tx_walk}, '0);
      chk("R9 rx_walk drop", {24'b0, rx_walk}, '0);
   endtask

   task automatic do_read(input logic [15:0] a, input logic [3:0] be, input string tag);
      logic [31:0] exp;
      int ix;
      ix  = int'(a[11:2]);
      exp = '0;
      if (taken(a, be) && kind(ix) != 2) exp = model[ix];
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_be = be;
      @(negedge clk);
      bus_valid = 1'b0;
      chk(tag, bus_rdata, exp);
   endtask

   function automatic logic [15:0] wa(input int ix);
      return 16'(ix * 4);
   endfunction

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL R9 watchdog act=hung exp=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 rdata at reset", bus_rdata, '0);
      chk("R9 tx_walk at reset", {24'b0, tx_walk}, '0);
      chk("R9 rx_walk at reset", {24'b0, rx_walk}, '0);

      // Whole-window sweep of reset contents, R1 R2 R8
      for (int ix = 0; ix < WORDS; ix++) do_read(wa(ix), 4'hF, "R8 reset sweep");

      // Generic access types, R3 R2
      do_write(wa(0), 32'hDEAD_BEEF, 4'hF, "R3 rw");
      do_read (wa(0), 4'hF, "R3 rw readback");
      do_write(wa(1), 32'h1234_5678, 4'hF, "R3 wo");
      do_read (wa(1), 4'hF, "R2 wo reads zero");
      do_write(wa(2), 32'h0F0F_00FF, 4'hF, "R3 w1c");
      do_read (wa(2), 4'hF, "R3 w1c readback");
      do_write(wa(3), 32'h0000_0000, 4'hF, "R3 ro");
      do_read (wa(3), 4'hF, "R3 ro unchanged");
      do_write(wa('h3FF), 32'hFFFF_FFFF, 4'hF, "R3 unclaimed");
      do_read (wa('h3FF), 4'hF, "R2 unclaimed reads zero");

      // Transmit halt word, one ring at a time then patterns, R4
      for (int i = 0; i < 8; i++) do_write(wa('h40), 32'h1 << (31 - i), 4'hF, "R4 tx single");
      do_read (wa('h40), 4'hF, "R4 tx stat cleared");
      do_write(wa('h40), 32'h3C00_0000, 4'hF, "R4 tx pattern");
      do_write(wa('h40), 32'h00FF_FFFF, 4'hF, "R4 tx low bits no walk");
      do_write(wa('h40), 32'hFF00_0000, 4'hF, "R4 tx all rings");

      // Receive halt word, walk only from a clear bit, R5
      do_write(wa('h50), 32'h0080_0000, 4'hF, "R5 rx bit set no walk");
      do_read (wa('h50), 4'hF, "R5 rx stat");
      do_write(wa('h50), 32'h0080_0000, 4'hF, "R5 rx bit clear walks");
      do_write(wa('h50), 32'h00FF_0000, 4'hF, "R5 rx mixed");
      do_write(wa('h50), 32'h00A5_0000, 4'hF, "R5 rx all clear pattern");
      do_write(wa('h50), 32'hFF00_FFFF, 4'hF, "R5 rx outside field");
      do_read (wa('h50), 4'hF, "R5 rx stat final");

      // Base registers and pointers, R6 R7
      for (int n = 0; n < 8; n++) begin
         do_write(wa('h60 + n), 32'h1000_0007 + 32'(n * 'h111), 4'hF, "R6 tx base");
         do_read (wa('h60 + n), 4'hF, "R6 tx base aligned");
         do_read (wa('h70 + n), 4'hF, "R6 tx ptr loaded");
         do_write(wa('h80 + n), 32'h2000_0005 + 32'(n * 'h223), 4'hF, "R7 rx base");
         do_read (wa('h80 + n), 4'hF, "R7 rx base aligned");
         do_read (wa('h90 + n), 4'hF, "R7 rx ptr loaded");
      end
      do_write(wa('h73), 32'hCAFE_0003, 4'hF, "R7 ptr direct write");
      do_read (wa('h73), 4'hF, "R7 ptr direct readback");
      do_write(wa('h63), 32'h0000_4441, 4'hF, "R6 base reloads ptr");
      do_read (wa('h73), 4'hF, "R6 ptr reloaded");

      // Ignored accesses, R10 R1
      do_write(wa(0), 32'h5555_5555, 4'h7, "R10 partial be write");
      do_read (wa(0), 4'hF, "R10 rw unchanged");
      do_write(16'h1000 | wa('h40), 32'hFFFF_FFFF, 4'hF, "R10 out of window tx");
      do_write(16'h8000 | wa('h50), 32'hFFFF_FFFF, 4'hF, "R10 out of window rx");
      do_write(wa('h40) | 16'h2, 32'hFFFF_FFFF, 4'hF, "R1 misaligned write");
      do_read (wa('h40), 4'hF, "R10 tx stat unchanged");
      do_read (wa(3) | 16'h1000, 4'hF, "R1 out of window read zero");
      do_read (wa(3) | 16'h1, 4'hF, "R1 misaligned read zero");
      do_read (wa(3), 4'hE, "R10 partial be read zero");
      do_read (wa(3), 4'hF, "R2 ro after ignored");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule